// File: doc/BRIEF.md
# Multiplexed Address Latch and Chip-Select Decoder

This block sits between a processor whose high address byte shares pins with the low byte and a bank of up to four memory devices. Six address bits from the shared bus are held in a storage register while a capture strobe is high. They then stay put once the strobe drops, so the high byte remains valid after the bus has moved on to the low byte. The four lowest captured bits leave the block as high-order address lines. The two upper captured bits select one of four active-low chip-select lines. With four 4K-byte devices this covers a 16K-byte space.

The storage register is sampled on the system clock: on each rising edge at which the capture strobe is high, the register loads the bus. If the capture strobe is tied high, the register reloads on every edge and the block serves a non-multiplexed bus. The chip selects come from the stored bits and from the present levels of chip enable and, when the strobe-gating parameter is set, of the read and write strobes.

Top module: `mux_addr_latch_dec`

## Requirements
- R1: While `rstN` is low, the stored value is zero, so `highAddr` reads 0.
- R2: On a rising `clk` edge with `latchEn` high, the stored value takes `addrIn`, and `highAddr` shows `addrIn[3:0]` from that edge on.
- R3: On a rising `clk` edge with `latchEn` low, the stored value and `highAddr` are unchanged, whatever `addrIn` does.
- R4: With `latchEn` held high, `highAddr` follows `addrIn[3:0]` one clock behind on every cycle.
- R5: `highAddr` depends only on the stored value, not on `chipEn`, `rdStb` or `wrStb`.
- R6: When selection is enabled, `csN[n]` is 0 and the other three bits are 1, where n is the stored bits 5:4 read as an unsigned number (0 to 3). The outputs respond to the enables in the same cycle.
- R7: With `chipEn` low, `csN` is 4'b1111.
- R8: With `STROBE_GATE`=1 and both `rdStb` and `wrStb` low, `csN` is 4'b1111. Either strobe high (with `chipEn` high) enables selection.
- R9: At most one bit of `csN` is 0 at any time.
- R10: With `STROBE_GATE`=0, `rdStb` and `wrStb` have no effect on `csN`, and selection is enabled by `chipEn` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | 6 | Shared address bus bits (high byte phase) |
| latchEn | input | 1 | Capture strobe, active high |
| chipEn | input | 1 | Chip enable, active high |
| rdStb | input | 1 | Memory read strobe, active high |
| wrStb | input | 1 | Memory write strobe, active high |
| highAddr | output | 4 | Stored address bits 3:0 |
| csN | output | 4 | Active-low chip selects |

## Verification
A stored address reaches `highAddr` and the select pattern one clock after the rising edge that captured it. The chip-enable and strobe gating acts within the same cycle. The bench changes inputs on the falling edge and compares at the next falling edge, after the capturing rising edge. Each comparison therefore sees the new stored value together with the gating levels that are still applied. A behavioural model updated at each rising edge supplies the expected values. A second instance with gating off is compared against the same model.

// File: rtl/mal_pkg.sv
package mal_pkg;
  typedef struct packed {
    logic load;   // store the bus on this edge
    logic selOn;  // chip selects may assert
  } malCtl_t;
endpackage

// File: rtl/mal_ctl.sv
module mal_ctl
  import mal_pkg::*;
#(
  parameter bit STROBE_GATE = 1'b1
) (
  input  logic    latchEn,
  input  logic    chipEn,
  input  logic    rdStb,
  input  logic    wrStb,
  output malCtl_t ctl
);
  logic strobeOk;

  generate
    if (STROBE_GATE) begin : gStrobe
      assign strobeOk = rdStb | wrStb;
    end else begin : gNoStrobe
      logic unusedStrobes;
      assign unusedStrobes = rdStb ^ wrStb;
      assign strobeOk = 1'b1;
    end
  endgenerate

  always_comb begin
    ctl.load  = latchEn;
    ctl.selOn = chipEn & strobeOk;
  end
endmodule

// File: rtl/mal_dp.sv
module mal_dp
  import mal_pkg::*;
#(
  parameter int PASS_W = 4,
  parameter int SEL_W  = 2,
  localparam int NUM_CS = 1 << SEL_W,
  localparam int TOT_W  = PASS_W + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TOT_W-1:0]  addrIn,
  input  malCtl_t           ctl,
  output logic [PASS_W-1:0] highAddr,
  output logic [NUM_CS-1:0] csN
);
  logic [TOT_W-1:0] heldQ;
  logic [SEL_W-1:0] selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldQ <= '0;
    end else if (ctl.load) begin
      heldQ <= addrIn;
    end
  end

  assign highAddr = heldQ[PASS_W-1:0];
  assign selQ     = heldQ[TOT_W-1:PASS_W];

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : gDec
      assign csN[i] = ~(ctl.selOn && (selQ == SEL_W'(i)));
    end
  endgenerate
endmodule

// File: rtl/mux_addr_latch_dec.sv
module mux_addr_latch_dec
  import mal_pkg::*;
#(
  parameter int PASS_W      = 4,
  parameter int SEL_W       = 2,
  parameter bit STROBE_GATE = 1'b1,
  localparam int NUM_CS = 1 << SEL_W,
  localparam int TOT_W  = PASS_W + SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TOT_W-1:0]  addrIn,
  input  logic              latchEn,
  input  logic              chipEn,
  input  logic              rdStb,
  input  logic              wrStb,
  output logic [PASS_W-1:0] highAddr,
  output logic [NUM_CS-1:0] csN
);
  malCtl_t ctl;

  mal_ctl #(.STROBE_GATE(STROBE_GATE)) u_ctl (
    .latchEn(latchEn),
    .chipEn (chipEn),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .ctl    (ctl)
  );

  mal_dp #(.PASS_W(PASS_W), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .ctl     (ctl),
    .highAddr(highAddr),
    .csN     (csN)
  );
endmodule

// File: rtl/mal_checker.sv
module mal_checker #(
  parameter int PASS_W      = 4,
  parameter int NUM_CS      = 4,
  parameter int TOT_W       = 6,
  parameter bit STROBE_GATE = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [TOT_W-1:0]  addrIn,
  input logic              latchEn,
  input logic              chipEn,
  input logic              rdStb,
  input logic              wrStb,
  input logic [PASS_W-1:0] highAddr,
  input logic [NUM_CS-1:0] csN
);
  always_comb begin
    if (!rstN) begin
      AST_RESET_ZERO: assert (highAddr == '0); // R1
    end
  end

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |=> highAddr == $past(addrIn[PASS_W-1:0])); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !latchEn |=> $stable(highAddr)); // R3

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R9

  AST_CE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> csN == '1); // R7

  AST_STROBE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (STROBE_GATE && !rdStb && !wrStb) |-> csN == '1); // R8
endmodule

bind mux_addr_latch_dec mal_checker #(
  .PASS_W(PASS_W), .NUM_CS(NUM_CS), .TOT_W(TOT_W), .STROBE_GATE(STROBE_GATE)
) u_chk (.*);

// File: tb/mux_addr_latch_dec_tb.sv
module mux_addr_latch_dec_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] addrIn = '0;
  logic       latchEn = 1'b0, chipEn = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [3:0] highAddr, csN, highAddrNs, csNNs;
  int checks = 0, errors = 0, cycles = 0;
  int refLatch = 0;

  always #4 clk = ~clk;

  mux_addr_latch_dec #(.STROBE_GATE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .latchEn(latchEn), .chipEn(chipEn),
    .rdStb(rdStb), .wrStb(wrStb), .highAddr(highAddr), .csN(csN));

  mux_addr_latch_dec #(.STROBE_GATE(1'b0)) u_dutNs (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .latchEn(latchEn), .chipEn(chipEn),
    .rdStb(rdStb), .wrStb(wrStb), .highAddr(highAddrNs), .csN(csNNs));

  always @(posedge clk or negedge rstN) begin
    if (!rstN) refLatch <= 0;
    else if (latchEn) refLatch <= int'(addrIn);
  end

  function automatic int expCs(int lat, bit ce, bit rd, bit wr, bit gate);
    if (!ce || (gate && !rd && !wr)) return 15;
    return 15 & ~(1 << (lat / 16));
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(string hTag, string cTag);
    int ones;
    chk(hTag, int'(highAddr), refLatch % 16);
    chk(cTag, int'(csN), expCs(refLatch, chipEn, rdStb, wrStb, 1'b1));
    ones = 0;
    for (int i = 0; i < 4; i++) if (!csN[i]) ones++;
    chk("R9", (ones <= 1) ? 1 : 0, 1);
    chk("R10", int'(csNNs), expCs(refLatch, chipEn, rdStb, wrStb, 1'b0));
  endtask

  task automatic step(logic [5:0] a, bit le, bit ce, bit rd, bit wr, string hTag, string cTag);
    addrIn = a; latchEn = le; chipEn = ce; rdStb = rd; wrStb = wr;
    @(posedge clk);
    @(negedge clk);
    compareAll(hTag, cTag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    addrIn = 6'h3f; latchEn = 1'b1; chipEn = 1'b1; rdStb = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", int'(highAddr), 0);
    chk("R1", int'(csN), 14);
    @(negedge clk);
    rstN = 1'b1;
    // R2 R6: capture every value, selection enabled by read or write
    for (int v = 0; v < 64; v++) step(6'(v), 1'b1, 1'b1, v[0], ~v[0], "R2", "R6");
    // R3: hold while the capture strobe is low
    step(6'h25, 1'b1, 1'b1, 1'b1, 1'b0, "R2", "R6");
    for (int v = 0; v < 8; v++) step(6'(v * 9), 1'b0, 1'b1, 1'b1, 1'b0, "R3", "R6");
    // R7 R5: chip enable low, address lines unaffected
    step(6'h3a, 1'b1, 1'b0, 1'b1, 1'b1, "R5", "R7");
    step(6'h11, 1'b0, 1'b0, 1'b0, 1'b1, "R5", "R7");
    step(6'h11, 1'b0, 1'b1, 1'b0, 1'b1, "R5", "R6");
    // R8: both strobes low
    step(6'h2c, 1'b1, 1'b1, 1'b0, 1'b0, "R5", "R8");
    step(6'h07, 1'b0, 1'b1, 1'b0, 1'b0, "R5", "R8");
    step(6'h07, 1'b0, 1'b1, 1'b1, 1'b1, "R3", "R6");
    // R4: capture strobe held high, random traffic and gating
    for (int n = 0; n < 200; n++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step(r[5:0], 1'b1, r[6] | r[9], r[7], r[8], "R4", "R6");
    end
    // mixed random, including hold cycles
    for (int n = 0; n < 200; n++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step(r[5:0], r[9], r[6], r[7], r[8], "R3", "R8");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule